// File: doc/BRIEF.md
# Four-Way Gathering Receive Path with Two Storage Stages

This block collects four narrow input words into one output word of the same width. Each input has its own first-stage storage cell. The four cells share one clock enable and each has its own latch enable. A select value picks one cell's output and passes it to an internal node. A second storage cell takes that node and feeds the output. The second cell has its own latch enable and its own clock enable. Both stages are clocked by the same clock.

Every storage cell can behave as a transparent latch or as an edge-triggered register. It is built as a flip-flop with a bypass path, so no real latch is inferred. When a cell's latch enable is high, its input passes straight through, and the flip-flop copies the input at every rising edge. When the latch enable drops, the cell holds the input it saw at the last rising edge. While the latch enable is low, the cell loads on a rising edge only when its active-low clock enable is low. An active-high disable flag stands in for a three-state pad: it forces the output to zero and raises a high-impedance indicator.

Top module: `rxm_path`

## Requirements
- R1: While `cell_le[i]` is high, first-stage cell i passes `b_bus` slot i through to its output in the same cycle.
- R2: While `cell_le[i]` is low and `bank_ce_n` is low, cell i stores slot i of `b_bus` at the rising edge of `clk`. The cell shows that value from the next cycle on.
- R3: Slot i of `b_bus` occupies bits [4*i+3:4*i]. A `sel` value of 0, 1, 2 or 3 routes the output of cell 0, 1, 2 or 3, respectively, to the internal node.
- R4: While `cell_le[i]` is low and `bank_ce_n` is high, cell i keeps its stored value across clock edges, whatever slot i of `b_bus` does.
- R5: While `out_le` is high, the second stage passes the internal node straight to `a_out` in the same cycle.
- R6: While `out_le` is low, the second stage stores the internal node at a rising edge only if `out_ce_n` is low. While `out_ce_n` is high, the second stage keeps its value.
- R7: While `out_dis` is high, `a_out` is all zeros and `a_hiz` is 1. While `out_dis` is low, `a_hiz` is 0 and `a_out` carries the second-stage value.
- R8: A low `rst_n` clears all five stored values to zero at once, without waiting for a clock edge.
- R9: After a latch enable falls, its cell holds the input it saw at the last rising edge while that enable was still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both storage stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_bus | input | 16 | Four 4-bit input slots, slot i at bits [4*i+3:4*i] |
| cell_le | input | 4 | Per-cell transparency enables for the first stage |
| bank_ce_n | input | 1 | Shared active-low clock enable for the first stage |
| sel | input | 2 | Picks which first-stage cell feeds the internal node |
| out_le | input | 1 | Transparency enable for the second stage |
| out_ce_n | input | 1 | Active-low clock enable for the second stage |
| out_dis | input | 1 | Output disable, stands in for high impedance |
| a_out | output | 4 | Output word, zero while disabled |
| a_hiz | output | 1 | High while the output is disabled |

## Verification
Transparent paths, the select and the disable flag are combinational. An input change applied at a falling edge therefore shows at `a_out` in the same cycle. A load into either stage shows one cycle later, after the next rising edge. The bench drives all inputs at the falling edge and compares the outputs 1 ns later. At that point the outputs reflect the new inputs and the state left by the previous rising edge. It then lets the reference model take the rising edge with the same inputs. A reset applied in mid-run is checked before any clock edge follows, which confirms that the clear does not wait for the clock.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int unsigned WORD_W  = 4;
  localparam int unsigned N_SLOTS = 4;
  localparam int unsigned SEL_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
endpackage

// File: rtl/rxm_store_cell.sv
module rxm_store_cell #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         ce_n,
  output logic [W-1:0] dout
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;
  logic         load;

  always_comb begin
    load   = le | ~ce_n;
    held_d = load ? din : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign dout = le ? din : held_q;

  // R4 / R6: an idle cell that stays opaque keeps showing the same word
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && $past(!le && ce_n)) |-> (dout == $past(dout)));
endmodule

// File: rtl/rxm_select.sv
module rxm_select #(
  parameter int unsigned W  = 4,
  parameter int unsigned N  = 4,
  parameter int unsigned SW = 2
) (
  input  logic [N*W-1:0] din,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   dout
);
  logic [W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot[g] = din[g*W +: W];
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) dout = slot[i];
    end
  end
endmodule

// File: rtl/rxm_path.sv
module rxm_path
  import rxm_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned N  = N_SLOTS,
  parameter int unsigned SW = SEL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N*W-1:0] b_bus,
  input  logic [N-1:0] cell_le,
  input  logic         bank_ce_n,
  input  logic [SW-1:0] sel,
  input  logic         out_le,
  input  logic         out_ce_n,
  input  logic         out_dis,
  output logic [W-1:0] a_out,
  output logic         a_hiz
);
  logic [N*W-1:0] bank_out;
  logic [W-1:0]   node;
  logic [W-1:0]   stage2;

  for (genvar g = 0; g < N; g++) begin : g_bank
    rxm_store_cell #(.W(W)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (b_bus[g*W +: W]),
      .le   (cell_le[g]),
      .ce_n (bank_ce_n),
      .dout (bank_out[g*W +: W])
    );
  end

  rxm_select #(.W(W), .N(N), .SW(SW)) u_sel (
    .din (bank_out),
    .sel (sel),
    .dout(node)
  );

  rxm_store_cell #(.W(W)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (node),
    .le   (out_le),
    .ce_n (out_ce_n),
    .dout (stage2)
  );

  always_comb begin
    a_hiz = out_dis;
    a_out = out_dis ? '0 : stage2;
  end

  // R1 / R3 / R5: fully transparent path carries the selected input slot
  assert_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_le[sel] && out_le && !out_dis) |-> (a_out == b_bus[sel*W +: W]));

  // R6: a second-stage load shows the previous node value next cycle
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_le && !out_ce_n && !out_dis) |=>
      (out_le || out_dis || a_out == $past(node)));

  // R7: disabled output is quiet
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    a_hiz |-> (a_out == '0));
endmodule

// File: tb/sim_rxm_path.sv
module sim_rxm_path;
  localparam int W = 4;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N*W-1:0] b_bus;
  logic [N-1:0] cell_le;
  logic         bank_ce_n;
  logic [1:0]   sel;
  logic         out_le;
  logic         out_ce_n;
  logic         out_dis;
  logic [W-1:0] a_out;
  logic         a_hiz;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_q1 [N];
  logic [W-1:0] m_q2;

  always #10 clk = ~clk;

  rxm_path u0 (
    .clk(clk), .rst_n(rst_n), .b_bus(b_bus), .cell_le(cell_le),
    .bank_ce_n(bank_ce_n), .sel(sel), .out_le(out_le), .out_ce_n(out_ce_n),
    .out_dis(out_dis), .a_out(a_out), .a_hiz(a_hiz)
  );

  function automatic logic [W-1:0] cell_view(int i);
    return cell_le[i] ? b_bus[i*W +: W] : m_q1[i];
  endfunction

  function automatic logic [W-1:0] node_view();
    return cell_view(int'(sel));
  endfunction

  function automatic logic [W-1:0] exp_out();
    logic [W-1:0] s2;
    s2 = out_le ? node_view() : m_q2;
    return out_dis ? '0 : s2;
  endfunction

  task automatic compare(string tag);
    logic [W-1:0] e;
    e = exp_out();
    checks++;
    if (a_out !== e || a_hiz !== out_dis) begin
      errors++;
      $display("FAIL %s: a_out=%h a_hiz=%b expected a_out=%h a_hiz=%b",
               tag, a_out, a_hiz, e, out_dis);
    end
  endtask

  task automatic step(string tag);
    logic [W-1:0] nd;
    #1;
    compare(tag);
    @(posedge clk);
    nd = node_view();
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_q1[i] = '0;
      m_q2 = '0;
    end else begin
      if (out_le || !out_ce_n) m_q2 = nd;
      for (int i = 0; i < N; i++)
        if (cell_le[i] || !bank_ce_n) m_q1[i] = b_bus[i*W +: W];
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    cell_le = '0; bank_ce_n = 1'b1; out_le = 1'b0; out_ce_n = 1'b1;
    out_dis = 1'b0; sel = 2'd0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5183));
    for (int i = 0; i < N; i++) m_q1[i] = '0;
    m_q2 = '0;
    rst_n = 1'b0;
    b_bus = 16'hFFFF;
    quiet();
    @(negedge clk);
    step("R8 reset state");
    step("R8 reset state");
    rst_n = 1'b1;
    step("R8 after release");

    // R1 R3 R5: fully transparent, every select value
    cell_le = '1; out_le = 1'b1; b_bus = 16'h4B72;
    for (int s = 0; s < N; s++) begin
      sel = 2'(s);
      step("R3 transparent select");
    end
    b_bus = 16'h9E05;
    step("R1 transparent follow");

    // R9: cell 0 captures last value seen while enabled
    b_bus = 16'h0005; cell_le = 4'b0001; sel = 2'd0;
    step("R9 enabled edge");
    cell_le = '0; b_bus = 16'h000A;
    step("R9 captured value");
    b_bus = 16'h000C;
    step("R4 hold with clock enable off");

    // R2: shared clock enable loads opaque cells
    bank_ce_n = 1'b0; b_bus = 16'h31D6;
    step("R2 load edge");
    bank_ce_n = 1'b1; b_bus = 16'h0000;
    for (int s = 0; s < N; s++) begin
      sel = 2'(s);
      step("R2 loaded cells");
    end

    // R6: second stage load then hold
    sel = 2'd2; out_le = 1'b0; out_ce_n = 1'b0;
    step("R6 second stage load");
    out_ce_n = 1'b1; sel = 2'd1;
    step("R6 second stage hold");
    bank_ce_n = 1'b0; b_bus = 16'h8888;
    step("R6 hold while bank loads");
    bank_ce_n = 1'b1;
    step("R6 hold");

    // R7: disable flag
    out_dis = 1'b1;
    step("R7 disabled");
    out_dis = 1'b0;
    step("R7 re-enabled");

    // random mix
    for (int k = 0; k < 600; k++) begin
      b_bus     = 16'($urandom);
      cell_le   = 4'($urandom) & 4'($urandom);
      bank_ce_n = 1'($urandom);
      sel       = 2'($urandom);
      out_le    = ($urandom_range(3) == 0);
      out_ce_n  = 1'($urandom);
      out_dis   = ($urandom_range(7) == 0);
      step("R3 random pattern");
    end

    // R8: asynchronous clear in mid-run
    quiet();
    step("R4 before reset");
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) m_q1[i] = '0;
    m_q2 = '0;
    #1;
    compare("R8 async clear");
    out_le = 1'b1; cell_le = '1; b_bus = 16'h7777; sel = 2'd3;
    #1;
    compare("R1 transparent during reset");
    quiet();
    @(negedge clk);
    rst_n = 1'b1;
    step("R8 cleared after release");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule